// File: doc/BRIEF.md
# I2C Master Auto-Stop Command Sequencer

This block sits between the host side of an I2C master and a byte-level bus engine. The host sets up a transfer descriptor with two areas. Each area has an 8-bit byte count, a direction bit and a PEC request bit. The host also sets up an internal address of zero to three bytes and a 7-bit slave address. It then pulses `go` while `alt_en` is high. The descriptor is captured on that edge. The sequencer then issues, one command at a time, everything the transfer needs:

- START and the slave address byte.
- The internal address bytes.
- A repeated START when the direction turns to read, or when the second area begins.
- The data bytes.
- A STOP, sent without host action when the active area's byte count runs out.

Write data comes from the host through a request/valid handshake. Each byte read from the bus is handed back as a one-cycle strobe.

Each area has its own length counter. Only the counter of the active area decrements, once per completed data byte. The legacy read/write select input is ignored in this mode. PEC request bits are held and shown on an output but do not change the bus sequence.

The FSM has eight states:

| State | Purpose |
|---|---|
| IDLE | Waits for the start condition below. |
| START | Sends START. |
| ADDR | Sends the slave address byte. |
| IADDR | Sends internal address bytes. |
| RSTART | Sends a repeated START. |
| TXREQ | Waits for a write byte from the host. |
| DATA | Moves one data byte. |
| STOP | Sends STOP. |

Transitions:

- IDLE→START on `go && alt_en`.
- START→ADDR when the engine completes the command.
- ADDR→IADDR when internal address bytes are still due.
- ADDR→STOP when the active area's length is zero.
- ADDR→DATA for a read area.
- ADDR→TXREQ for a write area.
- IADDR→IADDR until the last internal address byte is sent.
- IADDR→STOP when the first area's length is zero.
- IADDR→RSTART when the first area is a read.
- IADDR→TXREQ when the first area is a write.
- RSTART→ADDR.
- TXREQ→DATA on `tx_valid`.
- DATA→DATA between read bytes.
- DATA→TXREQ between write bytes.
- DATA→RSTART after the first area's last byte when the second area is non-empty.
- DATA→STOP after the last byte of the final area.
- STOP→IDLE, with a `done` pulse.

Top module: `i2c_autostop_seq`

## Requirements
- R1: After reset, `busy`, `done`, `eng_valid`, `tx_req` and `rx_valid` are all 0.
- R2: A `go` pulse while `alt_en` is 0 starts nothing: `busy` stays 0 and no engine command is issued.
- R3: Lengths, directions, PEC bits, internal address and slave address are captured on the `go` edge. Changing those inputs afterwards does not change the running transfer.
- R4: Engine command codes on `eng_cmd` are 0 START, 1 repeated START, 2 WRITE (byte on `eng_wbyte`), 3 READ, 4 STOP. Every transfer opens with START, then a WRITE of `{sla, rw}`, where rw=1 means read.
- R5: If `ia_len` is N>0, the first address byte carries rw=0. It is followed by N WRITEs of `ia_bytes`, most significant configured byte first. A read first area then gets repeated START and `{sla,1}`. A write first area continues with data and no repeated START.
- R6: Each area moves exactly its length in data bytes. After the last byte of the final area, STOP is issued with no host action.
- R7: If the second area's length is 0, only the first area runs. Otherwise a repeated START and `{sla, dir1}` follow the first area's last byte, and no STOP comes between the areas.
- R8: Each READ drives `eng_ack`=1 (ACK), except the last byte of the final area, which drives 0 (NACK).
- R9: `legacy_rd` has no effect on any command or byte.
- R10: `pec_q` shows `{pec1, pec0}` as captured at `go`. The PEC bits do not change the command sequence.
- R11: If the first area's length is 0, the sequencer sends START, the address and any internal address bytes, then STOP.
- R12: `busy` is 1 from the cycle after `go` until `done`. `done` is a single-cycle pulse in the cycle after the STOP command completes.
- R13: Before each written data byte, `tx_req` stays high until `tx_valid`, and the byte on `tx_data` is the one written. Each READ completion gives a one-cycle `rx_valid` pulse with the engine's byte on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alt_en | input | 1 | Enables auto-stop sequencing |
| legacy_rd | input | 1 | Legacy read select, ignored |
| go | input | 1 | Start pulse, captures descriptor |
| len0 | input | 8 | First area byte count |
| len1 | input | 8 | Second area byte count |
| dir0 | input | 1 | First area direction, 1 = read |
| dir1 | input | 1 | Second area direction, 1 = read |
| pec0 | input | 1 | First area PEC request |
| pec1 | input | 1 | Second area PEC request |
| ia_len | input | 2 | Internal address byte count, 0..3 |
| ia_bytes | input | 24 | Internal address value |
| sla | input | 7 | Slave address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| pec_q | output | 2 | Captured PEC request bits |
| tx_req | output | 1 | Requests next write byte |
| tx_valid | input | 1 | Write byte offered |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Read byte strobe |
| rx_data | output | 8 | Read byte |
| eng_valid | output | 1 | Engine command valid |
| eng_cmd | output | 3 | Engine command code |
| eng_wbyte | output | 8 | Byte for WRITE commands |
| eng_ack | output | 1 | ACK (1) or NACK (0) after READ |
| eng_done | input | 1 | Engine finished current command |
| eng_rbyte | input | 8 | Byte returned by READ |

## Verification
The hardest situation to reach is a chained transfer: internal address bytes, then a read first area, then a non-empty second area. That path passes through two repeated STARTs, an ACK/NACK change at the very last byte, and handovers between the two counters. The stimulus sweeps every combination of first-area length 0 to 3, second-area length 0 or 2, both directions for each area and internal address length 0 to 3. A bench model of the engine logs every command. The log is compared with a transcript built in the bench from the requirements. Right after `go`, the descriptor inputs are overwritten with junk, and `legacy_rd` is driven opposite to the first direction, so any late sampling shows up in the transcript.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

    typedef enum logic [2:0] {
        CMD_START  = 3'd0,
        CMD_RSTART = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_READ   = 3'd3,
        CMD_STOP   = 3'd4
    } eng_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_IADDR,
        S_RSTART,
        S_TXREQ,
        S_DATA,
        S_STOP
    } seq_state_e;

    localparam int unsigned NUM_AREAS = 2;

endpackage

// File: rtl/i2c_as_lencnt.sv
module i2c_as_lencnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == W'(1));
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_autostop_seq.sv
module i2c_autostop_seq
    import i2c_as_pkg::*;
#(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned SLA_W  = 7,
    parameter int unsigned IA_MAX = 3,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alt_en,
    input  logic                       legacy_rd,
    input  logic                       go,
    input  logic [LEN_W-1:0]           len0,
    input  logic [LEN_W-1:0]           len1,
    input  logic                       dir0,
    input  logic                       dir1,
    input  logic                       pec0,
    input  logic                       pec1,
    input  logic [$clog2(IA_MAX+1)-1:0] ia_len,
    input  logic [BYTE_W*IA_MAX-1:0]   ia_bytes,
    input  logic [SLA_W-1:0]           sla,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 pec_q,
    output logic                       tx_req,
    input  logic                       tx_valid,
    input  logic [BYTE_W-1:0]          tx_data,
    output logic                       rx_valid,
    output logic [BYTE_W-1:0]          rx_data,
    output logic                       eng_valid,
    output logic [2:0]                 eng_cmd,
    output logic [BYTE_W-1:0]          eng_wbyte,
    output logic                       eng_ack,
    input  logic                       eng_done,
    input  logic [BYTE_W-1:0]          eng_rbyte
);
    localparam int unsigned IAW = $clog2(IA_MAX + 1);

    seq_state_e st_q, st_d;

    logic                      area_q;
    logic [IAW-1:0]            ia_n_q, ia_idx_q;
    logic                      ia_done_q;
    logic [SLA_W-1:0]          sla_q;
    logic [BYTE_W*IA_MAX-1:0]  ia_q, ia_sh;
    logic [NUM_AREAS-1:0]      dir_q, pec_r;
    logic [BYTE_W-1:0]         wbuf_q;
    logic                      done_q, rx_valid_q;
    logic [BYTE_W-1:0]         rx_data_q;

    logic [LEN_W-1:0]     len_in [NUM_AREAS];
    logic [NUM_AREAS-1:0] cnt_last, cnt_zero, cnt_dec;

    logic start_ok, cur_last, cur_zero, cur_dir, final_area, addr_pre;

    assign start_ok   = go && alt_en && (st_q == S_IDLE);
    assign len_in[0]  = len0;
    assign len_in[1]  = len1;
    assign cur_last   = cnt_last[area_q];
    assign cur_zero   = cnt_zero[area_q];
    assign cur_dir    = dir_q[area_q];
    assign final_area = area_q || cnt_zero[1];
    assign addr_pre   = (ia_n_q != '0) && !ia_done_q;
    assign ia_sh      = ia_q >> (BYTE_W * ia_idx_q);

    // one byte counter per descriptor area
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        assign cnt_dec[g] = (st_q == S_DATA) && eng_done && (area_q == 1'(g));
        i2c_as_lencnt #(.W(LEN_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start_ok),
            .load_val (len_in[g]),
            .dec      (cnt_dec[g]),
            .last     (cnt_last[g]),
            .zero     (cnt_zero[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_ok) st_d = S_START;
            S_START:  if (eng_done) st_d = S_ADDR;
            S_ADDR:
                if (eng_done) begin
                    if (addr_pre)      st_d = S_IADDR;
                    else if (cur_zero) st_d = S_STOP;
                    else if (cur_dir)  st_d = S_DATA;
                    else               st_d = S_TXREQ;
                end
            S_IADDR:
                if (eng_done && ia_idx_q == '0) begin
                    if (cur_zero)     st_d = S_STOP;
                    else if (cur_dir) st_d = S_RSTART;
                    else              st_d = S_TXREQ;
                end
            S_RSTART: if (eng_done) st_d = S_ADDR;
            S_TXREQ:  if (tx_valid) st_d = S_DATA;
            S_DATA:
                if (eng_done) begin
                    if (cur_last)     st_d = final_area ? S_STOP : S_RSTART;
                    else if (cur_dir) st_d = S_DATA;
                    else              st_d = S_TXREQ;
                end
            S_STOP:   if (eng_done) st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            area_q     <= 1'b0;
            ia_n_q     <= '0;
            ia_idx_q   <= '0;
            ia_done_q  <= 1'b0;
            sla_q      <= '0;
            ia_q       <= '0;
            dir_q      <= '0;
            pec_r      <= '0;
            wbuf_q     <= '0;
            done_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            done_q     <= (st_q == S_STOP) && eng_done;
            rx_valid_q <= (st_q == S_DATA) && eng_done && cur_dir;
            if ((st_q == S_DATA) && eng_done && cur_dir) rx_data_q <= eng_rbyte;
            if (start_ok) begin
                area_q    <= 1'b0;
                ia_n_q    <= ia_len;
                ia_idx_q  <= ia_len - 1'b1;
                ia_done_q <= 1'b0;
                sla_q     <= sla;
                ia_q      <= ia_bytes;
                dir_q     <= {dir1, dir0};
                pec_r     <= {pec1, pec0};
            end
            if ((st_q == S_IADDR) && eng_done) begin
                ia_idx_q <= ia_idx_q - 1'b1;
                if (ia_idx_q == '0) ia_done_q <= 1'b1;
            end
            if ((st_q == S_TXREQ) && tx_valid) wbuf_q <= tx_data;
            if ((st_q == S_DATA) && eng_done && cur_last && !final_area) area_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        eng_valid = 1'b0;
        eng_cmd   = CMD_START;
        eng_wbyte = '0;
        eng_ack   = 1'b0;
        unique case (st_q)
            S_START:  eng_valid = 1'b1;
            S_ADDR: begin
                eng_valid = 1'b1;
                eng_cmd   = CMD_WRITE;
                eng_wbyte = {sla_q, addr_pre ? 1'b0 : cur_dir};
            end
            S_IADDR: begin
                eng_valid = 1'b1;
                eng_cmd   = CMD_WRITE;
                eng_wbyte = ia_sh[BYTE_W-1:0];
            end
            S_RSTART: begin
                eng_valid = 1'b1;
                eng_cmd   = CMD_RSTART;
            end
            S_DATA: begin
                eng_valid = 1'b1;
                eng_cmd   = cur_dir ? CMD_READ : CMD_WRITE;
                eng_wbyte = cur_dir ? '0 : wbuf_q;
                eng_ack   = cur_dir && !(cur_last && final_area);
            end
            S_STOP: begin
                eng_valid = 1'b1;
                eng_cmd   = CMD_STOP;
            end
            default: ;
        endcase
    end

    assign busy     = (st_q != S_IDLE);
    assign done     = done_q;
    assign tx_req   = (st_q == S_TXREQ);
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;
    assign pec_q    = pec_r;

    // legacy_rd is deliberately unused in this mode
    logic unused_legacy;
    assign unused_legacy = legacy_rd;
endmodule

// File: rtl/i2c_autostop_seq_chk.sv
module i2c_autostop_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alt_en,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       tx_req,
    input logic       rx_valid,
    input logic       eng_valid,
    input logic [2:0] eng_cmd,
    input logic       eng_done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_valid && !tx_req); // R1

    AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !alt_en && !busy) |=> !busy); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done) |=> eng_valid && $stable(eng_cmd)); // R4

    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(eng_valid && eng_cmd == 3'd4 && eng_done)); // R12

    AST_RX_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(eng_valid && eng_cmd == 3'd3 && eng_done)); // R13
endmodule

bind i2c_autostop_seq i2c_autostop_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alt_en    (alt_en),
    .go        (go),
    .busy      (busy),
    .done      (done),
    .tx_req    (tx_req),
    .rx_valid  (rx_valid),
    .eng_valid (eng_valid),
    .eng_cmd   (eng_cmd),
    .eng_done  (eng_done)
);

// File: tb/i2c_autostop_seq_tb_top.sv
module i2c_autostop_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        alt_en = 1'b0, legacy_rd = 1'b0, go = 1'b0;
    logic [7:0]  len0 = '0, len1 = '0;
    logic        dir0 = 1'b0, dir1 = 1'b0, pec0 = 1'b0, pec1 = 1'b0;
    logic [1:0]  ia_len = '0;
    logic [23:0] ia_bytes = '0;
    logic [6:0]  sla = '0;
    logic        busy, done, tx_req, rx_valid, eng_valid, eng_ack;
    logic [1:0]  pec_q;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [7:0]  rx_data, eng_wbyte;
    logic [2:0]  eng_cmd;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rbyte = '0;

    i2c_autostop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .legacy_rd(legacy_rd), .go(go),
        .len0(len0), .len1(len1), .dir0(dir0), .dir1(dir1), .pec0(pec0), .pec1(pec1),
        .ia_len(ia_len), .ia_bytes(ia_bytes), .sla(sla),
        .busy(busy), .done(done), .pec_q(pec_q),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .eng_valid(eng_valid), .eng_cmd(eng_cmd), .eng_wbyte(eng_wbyte), .eng_ack(eng_ack),
        .eng_done(eng_done), .eng_rbyte(eng_rbyte)
    );

    int n_tests = 0, n_fail = 0;
    localparam logic [6:0]  SLA_V = 7'h2A;
    localparam logic [23:0] IA_V  = 24'hC3B2A1;

    // engine model log: {cmd[2:0], ack, byte[7:0]}
    logic [11:0] got [0:31];
    logic [11:0] exp_l [0:31];
    int got_n = 0, exp_n = 0, wait_c = 0, rd_ctr = 0, tx_ctr = 0, rx_ctr = 0, rx_bad = 0, done_cnt = 0;
    int cmd_seen = 0;

    always @(negedge clk) begin
        if (eng_valid) cmd_seen++;
        if (eng_done) eng_done = 1'b0;
        else if (eng_valid) begin
            if (wait_c == 1) begin
                wait_c = 0;
                if (got_n < 32) begin
                    case (eng_cmd)
                        3'd2: got[got_n] = {3'd2, 1'b0, eng_wbyte};
                        3'd3: begin
                            got[got_n] = {3'd3, eng_ack, 8'h00};
                            eng_rbyte = 8'h90 + 8'(rd_ctr);
                            rd_ctr++;
                        end
                        default: got[got_n] = {eng_cmd, 9'd0};
                    endcase
                end
                got_n++;
                eng_done = 1'b1;
            end else wait_c++;
        end
    end

    // host write-data side
    always @(negedge clk) begin
        if (tx_valid) tx_valid = 1'b0;
        else if (tx_req) begin
            tx_data  = 8'h50 + 8'(tx_ctr);
            tx_valid = 1'b1;
            tx_ctr++;
        end
    end

    // host read-data side and done counter
    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_data != 8'h90 + 8'(rx_ctr)) rx_bad++;
            rx_ctr++;
        end
        if (done) done_cnt++;
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    function automatic void push(input logic [11:0] e);
        if (exp_n < 32) exp_l[exp_n] = e;
        exp_n++;
    endfunction

    function automatic void push_data(input int n, input bit rd, input bit fin, inout int wr);
        for (int k = 0; k < n; k++) begin
            if (rd) push({3'd3, !(fin && k == n - 1), 8'h00});
            else begin
                push({3'd2, 1'b0, 8'h50 + 8'(wr)});
                wr++;
            end
        end
    endfunction

    // expected transcript from R4..R8, R11
    function automatic void build(input int l0, input int l1, input bit d0, input bit d1, input int ian);
        int wr = 0;
        exp_n = 0;
        push({3'd0, 9'd0});
        if (ian > 0) begin
            push({3'd2, 1'b0, SLA_V, 1'b0});
            for (int i = ian - 1; i >= 0; i--) push({3'd2, 1'b0, IA_V[8*i +: 8]});
            if (l0 != 0 && d0) begin
                push({3'd1, 9'd0});
                push({3'd2, 1'b0, SLA_V, 1'b1});
            end
        end else push({3'd2, 1'b0, SLA_V, d0});
        if (l0 != 0) begin
            push_data(l0, d0, l1 == 0, wr);
            if (l1 != 0) begin
                push({3'd1, 9'd0});
                push({3'd2, 1'b0, SLA_V, d1});
                push_data(l1, d1, 1'b1, wr);
            end
        end
        push({3'd4, 9'd0});
    endfunction

    task automatic run(input int l0, input int l1, input bit d0, input bit d1, input int ian, input bit [1:0] pec);
        string tag;
        bit same;
        int cyc = 0, exp_rd, exp_wr;
        got_n = 0; rd_ctr = 0; tx_ctr = 0; rx_ctr = 0; rx_bad = 0; done_cnt = 0;
        build(l0, l1, d0, d1, ian);
        exp_rd = (d0 && l0 != 0 ? l0 : 0) + (d1 && l0 != 0 ? l1 : 0);
        exp_wr = (!d0 && l0 != 0 ? l0 : 0) + (!d1 && l0 != 0 ? l1 : 0);
        @(negedge clk);
        alt_en = 1'b1; legacy_rd = ~d0; // R9: opposite of area direction
        len0 = 8'(l0); len1 = 8'(l1); dir0 = d0; dir1 = d1;
        pec0 = pec[0]; pec1 = pec[1];
        ia_len = 2'(ian); ia_bytes = IA_V; sla = SLA_V; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        // R3: scramble descriptor inputs after capture
        len0 = 8'hFF; len1 = 8'h77; dir0 = ~d0; dir1 = ~d1; pec0 = ~pec[0]; pec1 = ~pec[1];
        ia_len = 2'(ian + 1); ia_bytes = 24'h0; sla = 7'h00; legacy_rd = d0;
        check(busy == 1'b1, "R12 busy after go", busy, 1);
        check(pec_q == pec, "R10 pec_q captured", pec_q, pec);
        while (done_cnt == 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 2000, "R6 transfer completes (watchdog)", cyc, 0);
        if (l0 == 0)       tag = "R11";
        else if (ian > 0)  tag = "R5";
        else if (l1 != 0)  tag = "R7";
        else if (d0)       tag = "R8";
        else               tag = "R6";
        same = (got_n == exp_n);
        for (int i = 0; i < exp_n && i < 32; i++) if (got[i] != exp_l[i]) same = 1'b0;
        check(same, $sformatf("transcript %s R3 R9 R10 l0=%0d l1=%0d d0=%0d d1=%0d ia=%0d cmds",
                              tag, l0, l1, d0, d1, ian), got_n, exp_n);
        if (!same)
            for (int i = 0; i < exp_n && i < 32; i++)
                if (got[i] != exp_l[i]) $display("  entry %0d: got %03h exp %03h", i, got[i], exp_l[i]);
        check(got_n >= 2 && got[0] == 12'h000 && got[1][11:9] == 3'd2 && got[1][7:1] == SLA_V,
              "R4 START then address", got[1], {3'd2, 1'b0, SLA_V, 1'b0});
        check(rx_ctr == exp_rd && rx_bad == 0, "R13 rx bytes", rx_ctr, exp_rd);
        check(tx_ctr == exp_wr, "R13 tx handshakes", tx_ctr, exp_wr);
        repeat (3) @(negedge clk);
        check(done_cnt == 1 && busy == 1'b0, "R12 single done pulse, idle", done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && eng_valid == 0 && tx_req == 0 && rx_valid == 0,
              "R1 state under reset", {busy, done, eng_valid, tx_req, rx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && eng_valid == 0, "R1 idle after reset", {busy, eng_valid}, 0);
        // R2: go without alt_en
        alt_en = 1'b0; len0 = 8'd2; sla = SLA_V; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cmd_seen = 0;
        repeat (5) @(negedge clk);
        check(busy == 0 && cmd_seen == 0, "R2 go ignored without alt_en", cmd_seen, 0);
        for (int ian = 0; ian <= 3; ian++)
            for (int l0 = 0; l0 <= 3; l0++)
                for (int l1 = 0; l1 <= 2; l1 += 2)
                    for (int d = 0; d < 4; d++)
                        run(l0, l1, d[0], d[1], ian, 2'(l0 + ian));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule